// File: doc/BRIEF.md
# Store-to-Load Alias Detector

This block remembers how the most recent store of the current dispatch group addressed memory. For every load presented to it, it decides whether that load may read bytes the store wrote. The scheduler uses the result to keep such a load out of the same group.

Addresses are never computed. Each access names two operands: a base register tag and a second operand. The second operand is either an index register tag or a signed constant offset. Two operands are equal when both are registers with the same tag, or both are constants with the same value. A hit is reported in three cases:
- the load's operands match the store's operands in the same positions;
- they match crosswise;
- only the bases match and both second operands are constants whose byte ranges intersect.

A group-clear strobe forgets the recorded store. A new store capture replaces it.

Top module: `mad_alias_detect`

## Requirements
- R1: Size codes map to access widths as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, for both store and load.
- R2: A load whose base and second operand equal the recorded store's base and second operand produces a hit.
- R3: A load whose base equals the store's second operand, and whose second operand equals the store's base, produces a hit.
- R4: With only the bases equal and both second operands constant, and the store offset below the load offset, a hit is reported exactly when store offset plus store width exceeds the load offset. Equal bases with a register second operand that differs give no hit.
- R5: With only the bases equal and both second operands constant, and the store offset at or above the load offset, a hit is reported exactly when load offset plus load width exceeds the store offset.
- R6: While no store is recorded (after reset or clear), no query produces a hit, and `alias_hit` is 0 after reset.
- R7: A clear strobe erases the recorded store, so later queries see no store.
- R8: A new store capture overwrites the previous record, and only the newest store is compared.
- R9: Offsets are signed 16-bit two's-complement values. The range test uses signed arithmetic wide enough not to wrap.
- R10: `alias_hit` is registered: it shows the result of the query presented at the previous rising edge, and is 0 after a cycle without a query.
- R11: A query sees the record as it stood before the edge, even when a capture or clear happens in the same cycle. When a capture and a clear happen in the same cycle, the capture is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_clr | input | 1 | Start of a new dispatch group; forget the store |
| st_cap | input | 1 | Record the store described below |
| st_base_tag | input | 8 | Store base register tag |
| st_idx_tag | input | 8 | Store index register tag (used when not constant) |
| st_idx_const | input | 1 | Store second operand is a constant offset |
| st_off | input | 16 | Store signed constant offset |
| st_szc | input | 2 | Store size code |
| ld_req | input | 1 | Load query valid |
| ld_base_tag | input | 8 | Load base register tag |
| ld_idx_tag | input | 8 | Load index register tag (used when not constant) |
| ld_idx_const | input | 1 | Load second operand is a constant offset |
| ld_off | input | 16 | Load signed constant offset |
| ld_szc | input | 2 | Load size code |
| alias_hit | output | 1 | Registered overlap result of the previous query |

## Verification
A load query can coincide with a store capture, with a group clear, or with both. The bench provokes each case by driving the strobes and the query in one cycle. It then issues a follow-up query that identifies which record was in force. The same-cycle query must match the old store, the follow-up must reflect the new state, and capture must win over clear.

// File: rtl/mad_pkg.sv
package mad_pkg;
    localparam int TAG_W = 8;
    localparam int OFF_W = 16;
    localparam int SZC_W = 2;
    localparam int NB_W  = 4;
    localparam int RNG_W = OFF_W + 2;

    typedef enum logic [SZC_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } szc_e;

    typedef struct packed {
        logic             is_const;
        logic [TAG_W-1:0] tag;
        logic [OFF_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        opnd_t           base;
        opnd_t           idx;
        logic [NB_W-1:0] nbytes;
    } acc_t;

    function automatic logic [NB_W-1:0] code2bytes(input logic [SZC_W-1:0] c);
        return NB_W'(1) << c;
    endfunction

    function automatic opnd_t mk_base(input logic [TAG_W-1:0] t);
        opnd_t o;
        o.is_const = 1'b0;
        o.tag      = t;
        o.val      = '0;
        return o;
    endfunction

    function automatic opnd_t mk_idx(input logic c, input logic [TAG_W-1:0] t,
                                     input logic [OFF_W-1:0] v);
        opnd_t o;
        o.is_const = c;
        o.tag      = c ? '0 : t;
        o.val      = c ? v : '0;
        return o;
    endfunction

    function automatic logic opnd_eq(input opnd_t a, input opnd_t b);
        if (a.is_const != b.is_const) return 1'b0;
        if (a.is_const)               return a.val == b.val;
        return a.tag == b.tag;
    endfunction
endpackage

// File: rtl/mad_store_reg.sv
module mad_store_reg
    import mad_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic cap,
    input  acc_t cap_acc,
    output acc_t rec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec <= '0;
        end else if (cap) begin
            rec <= cap_acc;
        end else if (clr) begin
            rec <= '0;
        end
    end

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !cap) |=> (rec.nbytes == '0));

    p_capture_wins_r11: assert property (@(posedge clk) disable iff (rst)
        cap |=> (rec.nbytes != '0));
endmodule

// File: rtl/mad_range_cmp.sv
module mad_range_cmp
    import mad_pkg::*;
(
    input  logic [OFF_W-1:0] st_off,
    input  logic [NB_W-1:0]  st_bytes,
    input  logic [OFF_W-1:0] ld_off,
    input  logic [NB_W-1:0]  ld_bytes,
    output logic             ovl
);
    logic signed [RNG_W-1:0] so, lo, s_end, l_end;

    always_comb begin
        so    = RNG_W'($signed(st_off));
        lo    = RNG_W'($signed(ld_off));
        s_end = so + $signed({{(RNG_W-NB_W){1'b0}}, st_bytes});
        l_end = lo + $signed({{(RNG_W-NB_W){1'b0}}, ld_bytes});
        if (so < lo) ovl = s_end > lo;
        else         ovl = l_end > so;
    end

    always_comb begin
        if (st_bytes != '0 && ld_bytes != '0 && st_off == ld_off)
            a_same_off_r5: assert (ovl);
    end
endmodule

// File: rtl/mad_alias_detect.sv
module mad_alias_detect
    import mad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_clr,
    input  logic             st_cap,
    input  logic [TAG_W-1:0] st_base_tag,
    input  logic [TAG_W-1:0] st_idx_tag,
    input  logic             st_idx_const,
    input  logic [OFF_W-1:0] st_off,
    input  logic [SZC_W-1:0] st_szc,
    input  logic             ld_req,
    input  logic [TAG_W-1:0] ld_base_tag,
    input  logic [TAG_W-1:0] ld_idx_tag,
    input  logic             ld_idx_const,
    input  logic [OFF_W-1:0] ld_off,
    input  logic [SZC_W-1:0] ld_szc,
    output logic             alias_hit
);
    acc_t st_new, rec, ld_acc;
    logic rng_ovl, exact_m, cross_m, base_m, rng_m, any_m;

    always_comb begin
        st_new.base   = mk_base(st_base_tag);
        st_new.idx    = mk_idx(st_idx_const, st_idx_tag, st_off);
        st_new.nbytes = code2bytes(st_szc);
        ld_acc.base   = mk_base(ld_base_tag);
        ld_acc.idx    = mk_idx(ld_idx_const, ld_idx_tag, ld_off);
        ld_acc.nbytes = code2bytes(ld_szc);
    end

    mad_store_reg u_rec (
        .clk     (clk),
        .rst     (rst),
        .clr     (grp_clr),
        .cap     (st_cap),
        .cap_acc (st_new),
        .rec     (rec)
    );

    mad_range_cmp u_rng (
        .st_off   (rec.idx.val),
        .st_bytes (rec.nbytes),
        .ld_off   (ld_acc.idx.val),
        .ld_bytes (ld_acc.nbytes),
        .ovl      (rng_ovl)
    );

    always_comb begin
        exact_m = opnd_eq(ld_acc.base, rec.base) && opnd_eq(ld_acc.idx, rec.idx);
        cross_m = opnd_eq(ld_acc.base, rec.idx)  && opnd_eq(ld_acc.idx, rec.base);
        base_m  = opnd_eq(ld_acc.base, rec.base);
        rng_m   = base_m && rec.idx.is_const && ld_acc.idx.is_const && rng_ovl;
        any_m   = (rec.nbytes != '0) && (exact_m || cross_m || rng_m);
    end

    always_ff @(posedge clk) begin
        if (rst) alias_hit <= 1'b0;
        else     alias_hit <= ld_req && any_m;
    end

    p_reset_low_r6: assert property (@(posedge clk) rst |=> !alias_hit);

    p_empty_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_req && rec.nbytes == '0) |=> !alias_hit);

    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> !alias_hit);

    p_exact_hits_r2: assert property (@(posedge clk) disable iff (rst)
        (ld_req && rec.nbytes != '0 && ld_acc == {rec.base, rec.idx, ld_acc.nbytes})
        |=> alias_hit);
endmodule

// File: tb/mad_alias_detect_bench.sv
module mad_alias_detect_bench;
    import mad_pkg::*;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit    exp;
        string req;
    } item_t;

    logic             clk = 1'b0, rst = 1'b1, grp_clr = 1'b0, st_cap = 1'b0;
    logic [TAG_W-1:0] st_base_tag = '0, st_idx_tag = '0, ld_base_tag = '0, ld_idx_tag = '0;
    logic             st_idx_const = 1'b0, ld_idx_const = 1'b0, ld_req = 1'b0;
    logic [OFF_W-1:0] st_off = '0, ld_off = '0;
    logic [SZC_W-1:0] st_szc = '0, ld_szc = '0;
    logic             alias_hit;

    item_t sb_q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mad_alias_detect u_mad_alias_detect (
        .clk(clk), .rst(rst), .grp_clr(grp_clr), .st_cap(st_cap),
        .st_base_tag(st_base_tag), .st_idx_tag(st_idx_tag),
        .st_idx_const(st_idx_const), .st_off(st_off), .st_szc(st_szc),
        .ld_req(ld_req), .ld_base_tag(ld_base_tag), .ld_idx_tag(ld_idx_tag),
        .ld_idx_const(ld_idx_const), .ld_off(ld_off), .ld_szc(ld_szc),
        .alias_hit(alias_hit)
    );

    // monitor: compares the registered result just after each edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (alias_hit !== it.exp) begin
                n_bad++;
                $display("FAIL %s: alias_hit=%0b expected=%0b", it.req, alias_hit, it.exp);
            end
        end
    end

    task automatic store(input logic [TAG_W-1:0] b, input logic c,
                         input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] o,
                         input logic [SZC_W-1:0] s);
        st_cap = 1'b1; st_base_tag = b; st_idx_const = c; st_idx_tag = t;
        st_off = o; st_szc = s;
    endtask

    task automatic load(input logic [TAG_W-1:0] b, input logic c,
                        input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] o,
                        input logic [SZC_W-1:0] s);
        ld_req = 1'b1; ld_base_tag = b; ld_idx_const = c; ld_idx_tag = t;
        ld_off = o; ld_szc = s;
    endtask

    // finish the cycle set up at the current negedge and log its expectation
    task automatic commit(input bit exp, input string req);
        item_t it;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        st_cap = 1'b0; ld_req = 1'b0; grp_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_cmp++;
        if (alias_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 reset: alias_hit=%0b expected=0", alias_hit);
        end
        // R6: nothing recorded yet
        load(8'd5, 1'b0, 8'd7, 16'd0, SZ_WORD);        commit(0, "R6 empty record");
        // R10: capture only, no query
        store(8'd5, 1'b0, 8'd7, 16'd0, SZ_WORD);       commit(0, "R10 no query");
        load(8'd5, 1'b0, 8'd7, 16'd0, SZ_BYTE);        commit(1, "R2 exact match");
        load(8'd7, 1'b0, 8'd5, 16'd0, SZ_BYTE);        commit(1, "R3 commuted match");
        load(8'd5, 1'b0, 8'd9, 16'd0, SZ_WORD);        commit(0, "R4 base only, register index");
        // R8: overwrite with base 5 + const 8, 4 bytes
        store(8'd5, 1'b1, 8'd0, 16'd8, SZ_WORD);       commit(0, "R10 no query");
        load(8'd5, 1'b0, 8'd7, 16'd0, SZ_WORD);        commit(0, "R8 old store gone");
        load(8'd5, 1'b1, 8'd0, 16'd11, SZ_BYTE);       commit(1, "R4 8+4>11");
        load(8'd5, 1'b1, 8'd0, 16'd12, SZ_BYTE);       commit(0, "R4 8+4>12 false");
        load(8'd5, 1'b1, 8'd0, 16'd6, SZ_HALF);        commit(0, "R5 6+2>8 false");
        load(8'd5, 1'b1, 8'd0, 16'd6, SZ_WORD);        commit(1, "R5 6+4>8");
        load(8'd5, 1'b1, 8'd0, 16'd1, SZ_DBL);         commit(1, "R1 8-byte 1+8>8");
        load(8'd5, 1'b1, 8'd0, 16'd0, SZ_DBL);         commit(0, "R1 8-byte 0+8>8 false");
        load(8'd5, 1'b1, 8'd0, 16'd8, SZ_BYTE);        commit(1, "R5 equal offsets");
        load(8'd6, 1'b1, 8'd0, 16'd8, SZ_BYTE);        commit(0, "R4 base mismatch");
        // R9: negative store offset
        store(8'd5, 1'b1, 8'd0, 16'hFFFC, SZ_DBL);     commit(0, "R10 no query");
        load(8'd5, 1'b1, 8'd0, 16'd2, SZ_BYTE);        commit(1, "R9 -4+8>2");
        load(8'd5, 1'b1, 8'd0, 16'd4, SZ_BYTE);        commit(0, "R9 -4+8>4 false");
        store(8'd5, 1'b1, 8'd0, 16'h7FFF, SZ_DBL);     commit(0, "R10 no query");
        load(8'd5, 1'b1, 8'd0, 16'h8000, SZ_DBL);      commit(0, "R9 no wrap at extremes");
        // R11: capture and query together, query sees old record
        store(8'd3, 1'b0, 8'd4, 16'd0, SZ_HALF);
        load(8'd5, 1'b1, 8'd0, 16'h7FFF, SZ_BYTE);     commit(1, "R11 query sees old store");
        load(8'd3, 1'b0, 8'd4, 16'd0, SZ_BYTE);        commit(1, "R8 new store in force");
        // R7 and R11: clear with a query in the same cycle
        grp_clr = 1'b1;
        load(8'd3, 1'b0, 8'd4, 16'd0, SZ_BYTE);        commit(1, "R11 query before clear");
        load(8'd3, 1'b0, 8'd4, 16'd0, SZ_BYTE);        commit(0, "R7 cleared");
        // R11: capture and clear together, capture kept
        grp_clr = 1'b1;
        store(8'd1, 1'b0, 8'd2, 16'd0, SZ_BYTE);       commit(0, "R10 no query");
        load(8'd2, 1'b0, 8'd1, 16'd0, SZ_BYTE);        commit(1, "R11 capture beats clear");
        grp_clr = 1'b1;                                 commit(0, "R10 no query");
        load(8'd1, 1'b0, 8'd2, 16'd0, SZ_BYTE);        commit(0, "R7 cleared again");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 queue: left=%0d expected=0", sb_q.size());
        end
        finish_run();
    end
endmodule